// File: doc/BRIEF.md
# Fault Status Register with Latching

This block keeps the condition word that a power-management slave presents to a host over a serial management bus. Live fault inputs are registered every cycle and show the present condition. They are not frozen at the first fault. Beside that view sits a latched alarm word. It collects every condition seen since the host last read or cleared the register. Communication error strobes, for a checksum error and a malformed-data error, set sticky bits. A successful host read does not clear those bits; only a clear-faults command does.

Two event flags keep evidence of short faults that have already passed. The restart flag records an automatic restart after a momentary shutdown. The changed flag records that the contents moved since the last host read. The alert output is active low. It stays low while the changed flag or any sticky communication bit is set.

A read strobe with its success flag captures the whole word into a snapshot register. The snapshot holds the pre-clear values of that cycle. In the same cycle, every non-communication item is cleared.

Top module: `fault_status_reg`

## Requirements
- R1: While rst is high and on the first cycle after it, status_o, alarm_o, comm_o, restart_o, changed_o and rd_word_o are all zero and alert_n_o is 1.
- R2: status_o equals the value of cond_i one clock earlier, whatever the read and clear strobes do.
- R3: alarm_o ORs in cond_i every cycle. In a cycle with rd_ok_i or clr_i high, it is reloaded with that cycle's cond_i instead.
- R4: A comm_err_i bit that is high sets the matching comm_o bit on the next clock. The bit stays set through reads. Only clr_i clears it, and an error strobe in the same cycle as clr_i leaves its bit set.
- R5: restart_i sets restart_o on the next clock. rd_ok_i or clr_i clears it, unless restart_i is high in that same cycle.
- R6: changed_o sets on the next clock after any change event. A change event is cond_i differing from status_o, a comm_err_i bit whose comm_o bit is not being kept, or restart_i while the restart flag is not being kept. A bit is kept when it is set and is not cleared in that cycle.
- R7: When there is no change event, rd_ok_i or clr_i clears changed_o on the next clock. A change event in the same cycle as clr_i or rd_ok_i leaves changed_o set.
- R8: alert_n_o is 0 exactly when changed_o is 1 or any comm_o bit is 1. It updates on the same clock as those flags.
- R9: On the clock after rd_ok_i, rd_word_o holds the values from before that cycle's clearing. The layout is {changed, restart, comm, alarm, status}, with status in the low NCOND bits. rd_word_o keeps its value when rd_ok_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cond_i | input | NCOND | Live condition inputs |
| comm_err_i | input | NCOMM | Communication error strobes (bit 0 checksum, bit 1 data) |
| rd_ok_i | input | 1 | Single-cycle pulse: host read completed successfully |
| clr_i | input | 1 | Single-cycle clear-faults command |
| restart_i | input | 1 | Single-cycle automatic restart event |
| status_o | output | NCOND | Registered live conditions |
| alarm_o | output | NCOND | Latched conditions since last read or clear |
| comm_o | output | NCOMM | Sticky communication error bits |
| restart_o | output | 1 | Restart event flag |
| changed_o | output | 1 | Changed-since-read flag |
| alert_n_o | output | 1 | Active-low alert |
| rd_word_o | output | 2*NCOND+NCOMM+2 | Snapshot returned by the last successful read |

## Verification
The hardest case to reach is a clear or read that lands in the same cycle as a new event. Examples are a checksum error together with clear-faults, a restart together with a read, or a condition edge together with either strobe. In those cycles the new event must win. Random stimulus with a fixed seed makes condition edges, error strobes and read and clear pulses sparse but overlapping, so such collisions happen many times. Directed steps also force each collision once and check alert release after a read, both with and without sticky errors present.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  function automatic int word_width(input int ncond, input int ncomm);
    return 2 * ncond + ncomm + 2;
  endfunction
endpackage

// File: rtl/fsr_cond_track.sv
module fsr_cond_track #(
  parameter int NCOND = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOND-1:0] cond_i,
  input  logic             reload_i,
  output logic [NCOND-1:0] live_q,
  output logic [NCOND-1:0] latch_q,
  output logic             diff_o
);
  // live view: one register stage behind the inputs
  always_ff @(posedge clk) begin
    if (rst) live_q <= '0;
    else     live_q <= cond_i;
  end

  // history view: per-bit latch, reloaded with present state on read/clear
  for (genvar b = 0; b < NCOND; b++) begin : g_latch
    always_ff @(posedge clk) begin
      if (rst)           latch_q[b] <= 1'b0;
      else if (reload_i) latch_q[b] <= cond_i[b];
      else               latch_q[b] <= latch_q[b] | cond_i[b];
    end
  end

  assign diff_o = (cond_i != live_q);

  p_live_follow_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> live_q == $past(cond_i));
  p_latch_keep_r3: assert property (@(posedge clk) disable iff (rst)
    !reload_i |=> (latch_q & $past(latch_q)) == $past(latch_q));
endmodule

// File: rtl/fsr_sticky.sv
module fsr_sticky #(
  parameter int NBITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NBITS-1:0] set_i,
  input  logic             clr_i,
  output logic [NBITS-1:0] q,
  output logic             rise_o,
  output logic             any_next_o
);
  logic [NBITS-1:0] keep;
  logic [NBITS-1:0] nxt;

  for (genvar b = 0; b < NBITS; b++) begin : g_bit
    assign keep[b] = q[b] & ~clr_i;
    assign nxt[b]  = keep[b] | set_i[b];
    always_ff @(posedge clk) begin
      if (rst) q[b] <= 1'b0;
      else     q[b] <= nxt[b];
    end
  end

  assign rise_o     = |(set_i & ~keep);
  assign any_next_o = |nxt;

  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (q & $past(q)) == $past(q));
  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    |set_i |=> (q & $past(set_i)) == $past(set_i));
endmodule

// File: rtl/fsr_event.sv
module fsr_event (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic wipe_i,
  input  logic other_evt_i,
  input  logic comm_any_next_i,
  output logic restart_q,
  output logic changed_q,
  output logic alert_n_q
);
  logic rs_keep, rs_next, evt, chg_next;

  assign rs_keep  = restart_q & ~wipe_i;
  assign rs_next  = rs_keep | restart_i;
  assign evt      = other_evt_i | (restart_i & ~rs_keep);
  assign chg_next = evt | (changed_q & ~wipe_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      restart_q <= 1'b0;
      changed_q <= 1'b0;
      alert_n_q <= 1'b1;
    end else begin
      restart_q <= rs_next;
      changed_q <= chg_next;
      alert_n_q <= ~(chg_next | comm_any_next_i);
    end
  end

  p_restart_set_r5: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> restart_q);
  p_changed_set_r6: assert property (@(posedge clk) disable iff (rst)
    other_evt_i |=> changed_q);
  p_changed_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (changed_q && !wipe_i) |=> changed_q);
endmodule

// File: rtl/fault_status_reg.sv
module fault_status_reg #(
  parameter int NCOND = 8,
  parameter int NCOMM = 2,
  localparam int WORDW = fsr_pkg::word_width(NCOND, NCOMM)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCOND-1:0] cond_i,
  input  logic [NCOMM-1:0] comm_err_i,
  input  logic             rd_ok_i,
  input  logic             clr_i,
  input  logic             restart_i,
  output logic [NCOND-1:0] status_o,
  output logic [NCOND-1:0] alarm_o,
  output logic [NCOMM-1:0] comm_o,
  output logic             restart_o,
  output logic             changed_o,
  output logic             alert_n_o,
  output logic [WORDW-1:0] rd_word_o
);
  logic wipe, cond_diff, comm_rise, comm_any_next;

  assign wipe = rd_ok_i | clr_i;

  fsr_cond_track #(.NCOND(NCOND)) u_cond (
    .clk(clk), .rst(rst), .cond_i(cond_i), .reload_i(wipe),
    .live_q(status_o), .latch_q(alarm_o), .diff_o(cond_diff)
  );

  fsr_sticky #(.NBITS(NCOMM)) u_comm (
    .clk(clk), .rst(rst), .set_i(comm_err_i), .clr_i(clr_i),
    .q(comm_o), .rise_o(comm_rise), .any_next_o(comm_any_next)
  );

  fsr_event u_evt (
    .clk(clk), .rst(rst), .restart_i(restart_i), .wipe_i(wipe),
    .other_evt_i(cond_diff | comm_rise), .comm_any_next_i(comm_any_next),
    .restart_q(restart_o), .changed_q(changed_o), .alert_n_q(alert_n_o)
  );

  // snapshot of pre-clear contents
  always_ff @(posedge clk) begin
    if (rst)          rd_word_o <= '0;
    else if (rd_ok_i) rd_word_o <= {changed_o, restart_o, comm_o, alarm_o, status_o};
  end

  p_alert_r8: assert property (@(posedge clk) disable iff (rst)
    alert_n_o == !(changed_o || (comm_o != '0)));
  p_snap_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rd_ok_i |=> $stable(rd_word_o));
  p_snap_take_r9: assert property (@(posedge clk) disable iff (rst)
    rd_ok_i |=> rd_word_o[NCOND-1:0] == $past(status_o));
endmodule

// File: tb/sim_fault_status_reg.sv
module sim_fault_status_reg;
  localparam int NC = 8;
  localparam int NM = 2;
  localparam int W  = 2 * NC + NM + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NC-1:0] cond = '0;
  logic [NM-1:0] cerr = '0;
  logic rd = 1'b0, clr = 1'b0, rs = 1'b0;
  logic [NC-1:0] status, alarm;
  logic [NM-1:0] comm;
  logic restart, changed, alert_n;
  logic [W-1:0] word;

  always #4 clk = ~clk;  // 125 MHz

  fault_status_reg #(.NCOND(NC), .NCOMM(NM)) u0 (
    .clk(clk), .rst(rst), .cond_i(cond), .comm_err_i(cerr), .rd_ok_i(rd),
    .clr_i(clr), .restart_i(rs), .status_o(status), .alarm_o(alarm),
    .comm_o(comm), .restart_o(restart), .changed_o(changed),
    .alert_n_o(alert_n), .rd_word_o(word)
  );

  int checks = 0, errors = 0;
  logic [NC-1:0] m_cond, m_alarm;
  logic [NM-1:0] m_comm;
  logic m_rs, m_chg, m_alert_n;
  logic [W-1:0] m_word;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 status", W'(status), W'(m_cond));
    chk("R3 alarm", W'(alarm), W'(m_alarm));
    chk("R4 comm", W'(comm), W'(m_comm));
    chk("R5 restart", W'(restart), W'(m_rs));
    chk("R6 R7 changed", W'(changed), W'(m_chg));
    chk("R8 alert_n", W'(alert_n), W'(m_alert_n));
    chk("R9 rd_word", word, m_word);
  endtask

  task automatic model_reset();
    m_cond = '0; m_alarm = '0; m_comm = '0; m_rs = 1'b0;
    m_chg = 1'b0; m_alert_n = 1'b1; m_word = '0;
  endtask

  // applies the current inputs to the model (one clock edge)
  task automatic model_step();
    logic [NM-1:0] kc;
    logic kr, wipe, evt;
    wipe = rd | clr;
    kc = clr ? '0 : m_comm;
    kr = wipe ? 1'b0 : m_rs;
    evt = (cond != m_cond) || ((cerr & ~kc) != '0) || (rs && !kr);
    if (rd) m_word = {m_chg, m_rs, m_comm, m_alarm, m_cond};
    m_alarm = wipe ? cond : (m_alarm | cond);
    m_comm = kc | cerr;
    m_rs = kr | rs;
    m_chg = evt | (m_chg & ~wipe);
    m_alert_n = ~(m_chg | (|m_comm));
    m_cond = cond;
  endtask

  // drive inputs at negedge, then step model and wait for the next negedge
  task automatic cyc(input logic [NC-1:0] c, input logic [NM-1:0] e,
                     input logic r, input logic cl, input logic s);
    cond = c; cerr = e; rd = r; clr = cl; rs = s;
    model_step();
    @(negedge clk);
    check_all();
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model_reset();
    repeat (3) @(negedge clk);
    check_all();  // R1 during reset
    rst = 1'b0;
    cyc('0, '0, 0, 0, 0);  // R1 after reset: still zero
    chk("R1 alert idle", W'(alert_n), W'(1'b1));

    // directed: condition pulse then read
    cyc(8'h05, '0, 0, 0, 0);
    cyc(8'h00, '0, 0, 0, 0);
    cyc(8'h00, '0, 1, 0, 0);  // R9 snapshot, R3 reload, R7 changed clear
    cyc(8'h00, '0, 0, 0, 0);
    chk("R8 alert released after read", W'(alert_n), W'(1'b1));
    // checksum error survives read, cleared by clear-faults
    cyc(8'h00, 2'b01, 0, 0, 0);
    cyc(8'h00, '0, 1, 0, 0);
    cyc(8'h00, '0, 0, 0, 0);
    chk("R4 comm kept through read", W'(comm), W'(2'b01));
    chk("R8 alert held by comm", W'(alert_n), W'(1'b0));
    // clear-faults colliding with new data error
    cyc(8'h00, 2'b10, 0, 1, 0);
    chk("R4 new error wins clear", W'(comm), W'(2'b10));
    cyc(8'h00, '0, 0, 1, 0);
    chk("R4 clear empties comm", W'(comm), W'(2'b00));
    // restart colliding with read
    cyc(8'h00, '0, 0, 0, 1);
    cyc(8'h00, '0, 1, 0, 1);
    chk("R5 restart wins read", W'(restart), W'(1'b1));
    cyc(8'h00, '0, 1, 0, 0);
    chk("R5 read clears restart", W'(restart), W'(1'b0));
    // condition edge in the same cycle as clear
    cyc(8'h80, '0, 0, 1, 0);
    chk("R7 event wins clear", W'(changed), W'(1'b1));
    cyc(8'h80, '0, 0, 1, 0);
    chk("R7 clear drops changed", W'(changed), W'(1'b0));

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [NC-1:0] c;
      logic [NM-1:0] e;
      c = cond;
      if ($urandom_range(0, 5) == 0) c[$urandom_range(0, NC-1)] ^= 1'b1;
      e = ($urandom_range(0, 11) == 0) ? NM'($urandom) : '0;
      cyc(c, e, $urandom_range(0, 6) == 0, $urandom_range(0, 14) == 0,
          $urandom_range(0, 19) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule